// File: doc/BRIEF.md
# Divergent Path Issue Scheduler

This block manages control-flow divergence for a single warp of 32 lanes. It keeps a small table of independent paths, each with its own program counter and lane mask. Each cycle it issues one instruction: the PC and lane mask of one eligible path, chosen round-robin. A decode stage answers combinationally with the kind of instruction found at the issued PC. The block then updates the issuing path.

A conditional branch whose outcome differs across the path's lanes splits the path. The issuing slot follows the branch target with the taken lanes. The fall-through lanes are written into a free slot and can issue on the very next cycle, so the two sides of a conditional interleave. Reconvergence points and sync barriers share one wait operation. A waiting path parks until no path is still running. While paths wait, those parked at equal PCs are merged by ORing their masks. A lane-exit operation removes lanes, and a path left with no lanes is freed.

A warp is launched with a start pulse that loads one path with the given PC and mask.

Top module: `warp_path_sched`

## Requirements
- R1: After reset no instruction issues and `stall_o` is low. A `start_i` pulse clears the table and loads slot 0 with `start_pc_i`/`start_mask_i`. That path issues in the following cycle.
- R2: At most one instruction issues per cycle, and one always issues while any path is eligible. An issued mask is never empty and never holds a lane outside the live set.
- R3: A branch (`dec_op_i` = 1) whose taken lanes (`dec_lanes_i` AND path mask) and not-taken lanes are both non-empty splits the path. The issuing slot moves to `dec_target_i` with the taken lanes. The lowest-numbered free slot receives PC+1 with the not-taken lanes.
- R4: A branch that is uniform over the path's lanes allocates no slot. The path moves to `dec_target_i` if all of its lanes take the branch, otherwise to PC+1.
- R5: The issuing slot is the first eligible slot at or after a rotation pointer, wrapping around. After each issue the pointer moves to the slot after the chosen one.
- R6: A wait operation (`dec_op_i` = 2, used for both reconvergence and sync points) parks the path at PC+1. A parked path is not eligible.
- R7: If two parked paths hold equal PCs, the lower slot takes the OR of both masks and the higher slot is freed. At most one pair merges per cycle.
- R8: When every valid path is parked and no mergeable pair remains, all paths are released together.
- R9: A divergent branch with no free slot raises `stall_o` in the same cycle. The path keeps its PC and mask, and no slot is allocated.
- R10: An exit (`dec_op_i` = 3) removes the lanes in `dec_lanes_i` from the path, and the path advances to PC+1. A path left with no lanes is freed and never issues again.
- R11: Valid path masks are pairwise disjoint. Their union equals the start mask minus all exited lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the warp with one path |
| start_pc_i | input | PC_W | PC of the launched path |
| start_mask_i | input | LANES | Active lanes of the launched path |
| dec_op_i | input | 2 | Kind of the issued instruction: 0 plain, 1 branch, 2 wait, 3 exit |
| dec_lanes_i | input | LANES | Branch-taken lanes, or lanes that exit |
| dec_target_i | input | PC_W | Branch target PC |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_slot_o | output | SLOT_W | Table slot of the issuing path |
| issue_pc_o | output | PC_W | PC of the issued instruction |
| issue_mask_o | output | LANES | Lane mask of the issued instruction (zero when idle) |
| stall_o | output | 1 | Divergent branch refused because the table is full |

## Verification
The hardest state to reach from the ports is a full path table meeting one more divergent branch. Reaching it needs seven live splits, and none of the split-off paths may merge or be freed. The stimulus uses a chain of branches that each peel off a single lane toward its own wait point at a distinct PC. Because the PCs differ, the parked paths never merge, and the eighth split has to stall. The interleaving and the merge/release timing are swept over single-lane and uniform branch patterns and several start masks. Each issue record is compared against a trace derived from the taken and not-taken masks.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN  = 2'd0,
    OP_BRANCH = 2'd1,
    OP_WAIT   = 2'd2,
    OP_EXIT   = 2'd3
  } op_e;
endpackage

// File: rtl/wps_rr_pick.sv
module wps_rr_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  // reverse scan: last hit is the nearest slot at or after ptr_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_i) + k) % N]) begin
        found_o = 1'b1;
        idx_o   = W'((int'(ptr_i) + k) % N);
      end
    end
  end
endmodule

// File: rtl/wps_pair_find.sv
module wps_pair_find #(
  parameter int N    = 8,
  parameter int PC_W = 16,
  localparam int W   = $clog2(N)
) (
  input  logic [N-1:0]    cand_i,
  input  logic [PC_W-1:0] pc_i [N],
  output logic            found_o,
  output logic [W-1:0]    lo_o,
  output logic [W-1:0]    hi_o
);
  always_comb begin
    found_o = 1'b0;
    lo_o    = '0;
    hi_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      for (int j = N - 1; j > i; j--) begin
        if (cand_i[i] && cand_i[j] && pc_i[i] == pc_i[j]) begin
          found_o = 1'b1;
          lo_o    = W'(i);
          hi_o    = W'(j);
        end
      end
    end
  end
endmodule

// File: rtl/warp_path_sched.sv
module warp_path_sched #(
  parameter int LANES = 32,
  parameter int SLOTS = 8,
  parameter int PC_W  = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic [LANES-1:0]  start_mask_i,
  input  logic [1:0]        dec_op_i,
  input  logic [LANES-1:0]  dec_lanes_i,
  input  logic [PC_W-1:0]   dec_target_i,
  output logic              issue_valid_o,
  output logic [SLOT_W-1:0] issue_slot_o,
  output logic [PC_W-1:0]   issue_pc_o,
  output logic [LANES-1:0]  issue_mask_o,
  output logic              stall_o
);
  import wps_pkg::*;

  logic [SLOTS-1:0]  vld_q, wt_q;
  logic [PC_W-1:0]   pc_q  [SLOTS];
  logic [LANES-1:0]  msk_q [SLOTS];
  logic [SLOT_W-1:0] rr_q;
  logic [LANES-1:0]  live_q;

  logic [SLOT_W-1:0] sel, free_idx, pair_lo, pair_hi, rr_nxt;
  logic              free_ok, pair_ok, all_wait, release_all;
  logic              is_br, diverge;
  logic [PC_W-1:0]   cur_pc, pc_inc;
  logic [LANES-1:0]  cur_msk, tk, nt;
  op_e               op;

  wps_rr_pick #(.N(SLOTS)) u_pick (
    .req_i(vld_q & ~wt_q), .ptr_i(rr_q), .found_o(issue_valid_o), .idx_o(sel)
  );

  wps_rr_pick #(.N(SLOTS)) u_free (
    .req_i(~vld_q), .ptr_i('0), .found_o(free_ok), .idx_o(free_idx)
  );

  wps_pair_find #(.N(SLOTS), .PC_W(PC_W)) u_pair (
    .cand_i(vld_q & wt_q), .pc_i(pc_q), .found_o(pair_ok), .lo_o(pair_lo), .hi_o(pair_hi)
  );

  always_comb begin
    op          = op_e'(dec_op_i);
    cur_pc      = pc_q[sel];
    cur_msk     = msk_q[sel];
    pc_inc      = cur_pc + PC_W'(1);
    tk          = cur_msk & dec_lanes_i;
    nt          = cur_msk & ~dec_lanes_i;
    is_br       = issue_valid_o && op == OP_BRANCH;
    diverge     = is_br && (|tk) && (|nt);
    stall_o     = diverge && !free_ok;
    all_wait    = (|vld_q) && ((vld_q & ~wt_q) == '0);
    release_all = all_wait && !pair_ok;
    rr_nxt      = (int'(sel) == SLOTS - 1) ? '0 : sel + SLOT_W'(1);
  end

  assign issue_slot_o = sel;
  assign issue_pc_o   = cur_pc;
  assign issue_mask_o = issue_valid_o ? cur_msk : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      wt_q   <= '0;
      rr_q   <= '0;
      live_q <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        pc_q[s]  <= '0;
        msk_q[s] <= '0;
      end
    end else if (start_i) begin
      vld_q    <= SLOTS'(1);
      wt_q     <= '0;
      rr_q     <= '0;
      live_q   <= start_mask_i;
      pc_q[0]  <= start_pc_i;
      msk_q[0] <= start_mask_i;
    end else begin
      // merge/release touch parked slots only; issue touches an eligible one
      if (pair_ok) begin
        msk_q[pair_lo] <= msk_q[pair_lo] | msk_q[pair_hi];
        vld_q[pair_hi] <= 1'b0;
      end else if (release_all) begin
        wt_q <= '0;
      end
      if (issue_valid_o) begin
        rr_q <= rr_nxt;
        unique case (op)
          OP_BRANCH: begin
            if (tk == '0) begin
              pc_q[sel] <= pc_inc;
            end else if (nt == '0) begin
              pc_q[sel] <= dec_target_i;
            end else if (free_ok) begin
              pc_q[sel]       <= dec_target_i;
              msk_q[sel]      <= tk;
              vld_q[free_idx] <= 1'b1;
              wt_q[free_idx]  <= 1'b0;
              pc_q[free_idx]  <= pc_inc;
              msk_q[free_idx] <= nt;
            end
          end
          OP_WAIT: begin
            wt_q[sel] <= 1'b1;
            pc_q[sel] <= pc_inc;
          end
          OP_EXIT: begin
            msk_q[sel] <= nt;
            live_q     <= live_q & ~tk;
            pc_q[sel]  <= pc_inc;
            if (nt == '0) vld_q[sel] <= 1'b0;
          end
          default: pc_q[sel] <= pc_inc;
        endcase
      end
    end
  end

  // invariant bookkeeping for checks only
  logic [LANES-1:0] union_msk;
  int               pop_sum;
  always_comb begin
    union_msk = '0;
    pop_sum   = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (vld_q[s]) begin
        union_msk = union_msk | msk_q[s];
        pop_sum   = pop_sum + $countones(msk_q[s]);
      end
    end
  end

  AST_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_sum == $countones(union_msk)); // R11
  AST_UNION_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    union_msk == live_q); // R11
  AST_ISSUE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (issue_mask_o != '0 && (issue_mask_o & ~live_q) == '0)); // R2
  AST_NO_PARKED_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (vld_q[sel] && !wt_q[sel])); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !start_i) |=> (pc_q[$past(sel)] == $past(issue_pc_o)
                               && msk_q[$past(sel)] == $past(issue_mask_o))); // R9
  AST_MERGE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_ok && !start_i) |=> !vld_q[$past(pair_hi)]); // R7
endmodule

// File: tb/tb_warp_path_sched.sv
module tb_warp_path_sched;
  localparam int L = 32;
  localparam int S = 8;
  localparam int P = 16;
  localparam int SW = $clog2(S);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [P-1:0]  start_pc = '0;
  logic [L-1:0]  start_mask = '0;
  logic [1:0]    dec_op;
  logic [L-1:0]  dec_lanes;
  logic [P-1:0]  dec_target;
  logic          issue_valid;
  logic [SW-1:0] issue_slot;
  logic [P-1:0]  issue_pc;
  logic [L-1:0]  issue_mask;
  logic          stall;

  always #4 clk = ~clk;

  warp_path_sched #(.LANES(L), .SLOTS(S), .PC_W(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_pc_i(start_pc),
    .start_mask_i(start_mask), .dec_op_i(dec_op), .dec_lanes_i(dec_lanes),
    .dec_target_i(dec_target), .issue_valid_o(issue_valid), .issue_slot_o(issue_slot),
    .issue_pc_o(issue_pc), .issue_mask_o(issue_mask), .stall_o(stall)
  );

  // program model: 0 diamond, 1 lane-peeling chain, 2 exits
  int           mode = 0;
  logic [L-1:0] pat = '0;
  always_comb begin
    dec_op = 2'd0; dec_lanes = '0; dec_target = '0;
    case (mode)
      0: case (issue_pc)
        16'd0: begin dec_op = 2'd1; dec_lanes = pat; dec_target = 16'd3; end
        16'd2: begin dec_op = 2'd1; dec_lanes = '1; dec_target = 16'd4; end
        16'd4: dec_op = 2'd2;
        16'd6: begin dec_op = 2'd3; dec_lanes = '1; end
        default: ;
      endcase
      1: begin
        if (issue_pc <= 16'd8) begin
          dec_op = 2'd1; dec_lanes = 32'd1 << issue_pc[4:0];
          dec_target = 16'd40 + 16'd2 * issue_pc;
        end else if (issue_pc >= 16'd40 && !issue_pc[0]) dec_op = 2'd2;
      end
      default: case (issue_pc)
        16'd0: begin dec_op = 2'd1; dec_lanes = 32'h0000_FFFF; dec_target = 16'd3; end
        16'd1: begin dec_op = 2'd3; dec_lanes = '1; end
        16'd3: begin dec_op = 2'd3; dec_lanes = 32'h0000_00FF; end
        16'd5: begin dec_op = 2'd3; dec_lanes = '1; end
        default: ;
      endcase
    endcase
  end

  int errs = 0;
  int checks = 0;

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // record word {valid, slot, pc, mask}; zero when idle
  logic [63:0] exp_q [24];
  int          exp_n;
  function automatic logic [63:0] rec(input int s, input int pc, input logic [L-1:0] m);
    return {12'd0, 1'b1, SW'(s), P'(pc), m};
  endfunction
  function automatic logic [63:0] act_rec();
    return issue_valid ? {12'd0, 1'b1, issue_slot, issue_pc, issue_mask} : 64'd0;
  endfunction
  task automatic push(input logic [63:0] r);
    exp_q[exp_n] = r; exp_n++;
  endtask

  task automatic launch(input logic [L-1:0] m);
    @(negedge clk); start_i = 1'b1; start_pc = '0; start_mask = m;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run_trace(input string tag, input logic [L-1:0] live);
    for (int c = 0; c < exp_n; c++) begin
      check_eq(tag, act_rec(), exp_q[c]);
      if (issue_valid)
        check_eq("R2 issued mask non-empty within live lanes",
                 64'((issue_mask != '0) && ((issue_mask & ~live) == '0)), 64'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [L-1:0] masks [3];
    logic [L-1:0] t, f;
    int stall_seen;
    int bad_pc;
    masks[0] = '1; masks[1] = 32'h0F0F_00FF; masks[2] = 32'h8000_0001;
    repeat (3) @(negedge clk);
    check_eq("R1 reset idle", {62'd0, issue_valid, stall}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 idle after reset release", {62'd0, issue_valid, stall}, 64'd0);

    // diamond sweep
    mode = 0;
    for (int mi = 0; mi < 3; mi++) begin
      for (int pi = 0; pi < 35; pi++) begin
        logic [L-1:0] m;
        m = masks[mi];
        pat = (pi < 32) ? (32'd1 << pi) : (pi == 32) ? 32'd0 : (pi == 33) ? '1 : 32'hAAAA_AAAA;
        t = m & pat; f = m & ~pat;
        exp_n = 0;
        push(rec(0, 0, m));
        if (t != '0 && f != '0) begin
          push(rec(1, 1, f)); push(rec(0, 3, t)); push(rec(1, 2, f));
          push(rec(0, 4, t)); push(rec(1, 4, f)); push(64'd0); push(64'd0);
          push(rec(0, 5, m)); push(rec(0, 6, m)); push(64'd0);
          launch(m);
          run_trace("R3 R5 R6 R7 R8 divergent diamond", m);
        end else begin
          if (f == '0) push(rec(0, 3, m));
          else begin push(rec(0, 1, m)); push(rec(0, 2, m)); end
          push(rec(0, 4, m)); push(64'd0); push(rec(0, 5, m)); push(rec(0, 6, m));
          push(64'd0);
          launch(m);
          run_trace("R4 R6 R8 uniform branch", m);
        end
      end
    end

    // exits: empty path freed, partial exit trims mask
    mode = 2;
    exp_n = 0;
    push(rec(0, 0, '1)); push(rec(1, 1, 32'hFFFF_0000)); push(rec(0, 3, 32'h0000_FFFF));
    push(rec(0, 4, 32'h0000_FF00)); push(rec(0, 5, 32'h0000_FF00));
    push(64'd0); push(64'd0); push(64'd0);
    launch('1);
    run_trace("R10 lane exit and path free", '1);

    // table full: eighth split must stall
    mode = 1;
    launch('1);
    stall_seen = 0; bad_pc = 0;
    for (int c = 0; c < 80; c++) begin
      if (stall) begin
        stall_seen++;
        check_eq("R9 stalled branch keeps pc and mask",
                 {16'd0, issue_pc, issue_mask}, {16'd0, 16'd7, ~32'h7F});
      end
      if (issue_valid && issue_pc == 16'd8) bad_pc++;
      @(negedge clk);
    end
    check_eq("R9 stall raised with full table", 64'(stall_seen > 10), 64'd1);
    check_eq("R9 refused branch never advanced", 64'(bad_pc), 64'd0);

    // restart clears a full table (R1)
    mode = 0; pat = '0;
    launch(32'h0000_0003);
    check_eq("R1 restart loads slot 0", act_rec(), rec(0, 0, 32'h3));
    finish_run();
  end
endmodule